// File: doc/BRIEF.md
# Address Remap and Region Decoder

This block turns a 32-bit system address into a select for one of six target regions and gives the offset of that address inside the selected region. The targets are the control register window, the configuration memory, the scratchpad SRAM, a window of memory-mapped functions, external Flash and external dynamic memory. The decode itself is combinational. A small register file, written over a simple write-only register bus, holds the settings that can be moved or switched.

After reset, the Flash image also appears at address zero, so a processor that boots from zero runs Flash code. Software later branches into the real Flash window and writes the clear-map control. From then on, the bottom of memory holds a scratchpad alias, where fast code such as vector tables can be placed. An overlay control can give the scratchpad alias precedence at the bottom while the Flash alias is still on. The function window is described by a start address and a power-of-two size, and it extends downward from its start.

Top module: `addr_remap_decoder`

## Requirements
- R1: After reset the Flash alias is on, the overlay bit is 0, the scratchpad window is at 0x2000_0000 and the function window covers 0x0FF0_0000 to 0x0FFF_FFFF. In this state address 0x100 selects Flash with offset 0x100.
- R2: The control register window covers 64 KB from 0xFF00_0000. The configuration memory window covers 256 KB from 0xFE00_0000. Both take precedence over every other region.
- R3: The real Flash window covers 16 MB from 0xF000_0000. Dynamic memory covers 256 MB from 0x0000_0000 and has the lowest precedence.
- R4: With start S (register 3, bits 31:12) and size 2^k (register 4, bits 4:0 = k), the function window covers S−2^k up to S−1 and takes precedence over the scratchpad window, Flash and dynamic memory.
- R5: A write to register 4 changes the size only when k is between 12 and 20. Any other value leaves the previous size in place.
- R6: A write to register 0 with bit 0 = 1 turns the Flash alias off until the next reset. A write with bit 0 = 0 has no effect. With the alias off, addresses 0 to 16 KB−1 select the scratchpad and addresses from 16 KB upward fall through to the lower-precedence regions.
- R7: Register 1 bit 0 set to 1 places the 16 KB scratchpad alias above the Flash alias at addresses 0 to 16 KB−1. The Flash alias keeps the rest of its 16 MB.
- R8: Register 2 bits 31:14 set the base of the 16 KB scratchpad window. The low bits of the written value are ignored.
- R9: Select bits are: bit 0 control, bit 1 configuration, bit 2 scratchpad, bit 3 function, bit 4 Flash, bit 5 dynamic memory. Exactly one bit is set whenever any region matches.
- R10: An address that matches no region raises decode_err, with all select bits and the offset at 0. Otherwise the offset is the address minus the base of the winning region, and that base is 0 for an alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register number |
| cfg_wr_data | input | 32 | Register write data |
| sys_addr | input | 32 | Address to decode |
| region_sel | output | 6 | One-hot region select |
| region_offset | output | 32 | Offset within the winning region |
| decode_err | output | 1 | No region matched |

## Verification
The decode is combinational, so a wrong internal setting cannot stay hidden. It shows up at the ports the moment an address falls in a window edge that the setting moves: a selects bit on the wrong region, an offset shifted by a base, or a spurious decode_err. The bench probes addresses on both sides of every window edge right after each register write, and after each write it tries illegal values to confirm that ignored values leave those edges in place. A Flash alias that comes back after being cleared, or an overlay applied in the wrong direction, changes the select for address 0x100 on the first probe after the write.

// File: rtl/addr_remap_pkg.sv
package addr_remap_pkg;
  localparam int AW   = 32;
  localparam int NRGN = 6;
  localparam int RW   = 3;

  typedef enum logic [RW-1:0] {
    RG_CTRL  = 3'd0,
    RG_CFG   = 3'd1,
    RG_SPAD  = 3'd2,
    RG_FUNC  = 3'd3,
    RG_FLASH = 3'd4,
    RG_DRAM  = 3'd5
  } region_e;

  typedef struct packed {
    logic          flash_alias;
    logic          spad_first;
    logic [AW-1:0] spad_base;
    logic [AW-1:0] func_start;
    logic [4:0]    func_lg;
  } remap_cfg_t;
endpackage

// File: rtl/addr_remap_regs.sv
module addr_remap_regs
  import addr_remap_pkg::*;
#(
  parameter int            SPAD_LG        = 14,
  parameter int            FUNC_MIN_LG    = 12,
  parameter int            FUNC_MAX_LG    = 20,
  parameter logic [AW-1:0] SPAD_BASE_RST  = 32'h2000_0000,
  parameter logic [AW-1:0] FUNC_START_RST = 32'h1000_0000,
  parameter int            FUNC_LG_RST    = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  output remap_cfg_t    cfg
);
  localparam logic [AW-1:0] SPAD_KEEP = ~((AW'(1) << SPAD_LG) - AW'(1));
  localparam logic [AW-1:0] FUNC_KEEP = ~((AW'(1) << FUNC_MIN_LG) - AW'(1));

  logic [1:0] rst_pipe;
  logic       rst_int_n;
  remap_cfg_t cfg_q, cfg_d;
  logic       size_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign size_ok = (int'(wr_data[4:0]) >= FUNC_MIN_LG) &&
                   (int'(wr_data[4:0]) <= FUNC_MAX_LG);

  always_comb begin
    cfg_d = cfg_q;
    case (wr_sel)
      3'd0: if (wr_data[0]) cfg_d.flash_alias = 1'b0;
      3'd1: cfg_d.spad_first = wr_data[0];
      3'd2: cfg_d.spad_base  = wr_data & SPAD_KEEP;
      3'd3: cfg_d.func_start = wr_data & FUNC_KEEP;
      3'd4: if (size_ok) cfg_d.func_lg = wr_data[4:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_q.flash_alias <= 1'b1;
      cfg_q.spad_first  <= 1'b0;
      cfg_q.spad_base   <= SPAD_BASE_RST;
      cfg_q.func_start  <= FUNC_START_RST;
      cfg_q.func_lg     <= 5'(FUNC_LG_RST);
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  AST_ALIAS_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cfg_q.flash_alias |=> !cfg_q.flash_alias); // R6
  AST_SIZE_RANGE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (int'(cfg_q.func_lg) >= FUNC_MIN_LG) && (int'(cfg_q.func_lg) <= FUNC_MAX_LG)); // R5
  AST_OVERLAY_TRACKS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && wr_sel == 3'd1) |=> (cfg_q.spad_first == $past(wr_data[0]))); // R7
endmodule

// File: rtl/addr_window_match.sv
module addr_window_match
  import addr_remap_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] span,
  output logic          hit,
  output logic [AW-1:0] offset
);
  assign offset = addr - lo;
  assign hit    = (addr >= lo) && (offset < span);
endmodule

// File: rtl/addr_region_arbiter.sv
module addr_region_arbiter
  import addr_remap_pkg::*;
#(
  parameter int NCAND = 9
) (
  input  logic [NCAND-1:0]         hit,
  input  logic [NCAND-1:0][AW-1:0] offs,
  input  logic [NCAND-1:0][RW-1:0] rgn,
  output logic [NRGN-1:0]          sel,
  output logic [AW-1:0]            offset,
  output logic                     err
);
  logic          any;
  logic [RW-1:0] win_rgn;
  logic [AW-1:0] win_off;

  always_comb begin
    any     = 1'b0;
    win_rgn = '0;
    win_off = '0;
    for (int i = NCAND - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any     = 1'b1;
        win_rgn = rgn[i];
        win_off = offs[i];
      end
    end
    for (int r = 0; r < NRGN; r++) sel[r] = any && (win_rgn == RW'(r));
  end

  assign offset = win_off;
  assign err    = !any;
endmodule

// File: rtl/addr_remap_decoder.sv
module addr_remap_decoder
  import addr_remap_pkg::*;
#(
  parameter logic [AW-1:0] CTRL_BASE      = 32'hFF00_0000,
  parameter logic [AW-1:0] CFG_BASE       = 32'hFE00_0000,
  parameter logic [AW-1:0] FLASH_BASE     = 32'hF000_0000,
  parameter logic [AW-1:0] DRAM_BASE      = 32'h0000_0000,
  parameter int            CTRL_LG        = 16,
  parameter int            CFG_LG         = 18,
  parameter int            SPAD_LG        = 14,
  parameter int            FLASH_LG       = 24,
  parameter int            DRAM_LG        = 28,
  parameter int            FUNC_MIN_LG    = 12,
  parameter int            FUNC_MAX_LG    = 20,
  parameter logic [AW-1:0] SPAD_BASE_RST  = 32'h2000_0000,
  parameter logic [AW-1:0] FUNC_START_RST = 32'h1000_0000,
  parameter int            FUNC_LG_RST    = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_en,
  input  logic [2:0]      cfg_wr_sel,
  input  logic [31:0]     cfg_wr_data,
  input  logic [31:0]     sys_addr,
  output logic [5:0]      region_sel,
  output logic [31:0]     region_offset,
  output logic            decode_err
);
  localparam int            NC       = 9;
  localparam logic [AW-1:0] CTRL_SZ  = AW'(1) << CTRL_LG;
  localparam logic [AW-1:0] CFG_SZ   = AW'(1) << CFG_LG;
  localparam logic [AW-1:0] SPAD_SZ  = AW'(1) << SPAD_LG;
  localparam logic [AW-1:0] FLASH_SZ = AW'(1) << FLASH_LG;
  localparam logic [AW-1:0] DRAM_SZ  = AW'(1) << DRAM_LG;

  remap_cfg_t              cfg;
  logic [AW-1:0]           func_sz;
  logic [NC-1:0][AW-1:0]   c_lo, c_span, c_off;
  logic [NC-1:0][RW-1:0]   c_rgn;
  logic [NC-1:0]           c_hit;

  addr_remap_regs #(
    .SPAD_LG(SPAD_LG), .FUNC_MIN_LG(FUNC_MIN_LG), .FUNC_MAX_LG(FUNC_MAX_LG),
    .SPAD_BASE_RST(SPAD_BASE_RST), .FUNC_START_RST(FUNC_START_RST),
    .FUNC_LG_RST(FUNC_LG_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel),
    .wr_data(cfg_wr_data), .cfg(cfg)
  );

  assign func_sz = AW'(1) << cfg.func_lg;

  // Candidate list in precedence order, lowest index wins.
  always_comb begin
    c_lo[0] = CTRL_BASE;                  c_span[0] = CTRL_SZ;  c_rgn[0] = RG_CTRL;
    c_lo[1] = CFG_BASE;                   c_span[1] = CFG_SZ;   c_rgn[1] = RG_CFG;
    c_lo[2] = '0;                         c_rgn[2] = RG_SPAD;
    c_span[2] = cfg.spad_first ? SPAD_SZ : '0;
    c_lo[3] = '0;                         c_rgn[3] = RG_FLASH;
    c_span[3] = cfg.flash_alias ? FLASH_SZ : '0;
    c_lo[4] = '0;                         c_span[4] = SPAD_SZ;  c_rgn[4] = RG_SPAD;
    c_lo[5] = cfg.func_start - func_sz;   c_span[5] = func_sz;  c_rgn[5] = RG_FUNC;
    c_lo[6] = cfg.spad_base;              c_span[6] = SPAD_SZ;  c_rgn[6] = RG_SPAD;
    c_lo[7] = FLASH_BASE;                 c_span[7] = FLASH_SZ; c_rgn[7] = RG_FLASH;
    c_lo[8] = DRAM_BASE;                  c_span[8] = DRAM_SZ;  c_rgn[8] = RG_DRAM;
  end

  for (genvar g = 0; g < NC; g++) begin : g_win
    addr_window_match u_match (
      .addr(sys_addr), .lo(c_lo[g]), .span(c_span[g]),
      .hit(c_hit[g]), .offset(c_off[g])
    );
  end

  addr_region_arbiter #(.NCAND(NC)) u_arb (
    .hit(c_hit), .offs(c_off), .rgn(c_rgn),
    .sel(region_sel), .offset(region_offset), .err(decode_err)
  );

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    decode_err ? (region_sel == '0) : $onehot(region_sel)); // R9
  AST_ERR_ZERO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    decode_err |-> (region_offset == '0)); // R10
  AST_CTRL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_addr[31:CTRL_LG] == CTRL_BASE[31:CTRL_LG]) |->
      (region_sel[RG_CTRL] && region_offset == (sys_addr - CTRL_BASE))); // R2
  AST_BOTTOM_SPAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg.spad_first || !cfg.flash_alias) && sys_addr < SPAD_SZ) |->
      (region_sel[RG_SPAD] && region_offset == sys_addr)); // R7
endmodule

// File: tb/test_addr_remap_decoder.sv
module test_addr_remap_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [2:0]  cfg_wr_sel;
  logic [31:0] cfg_wr_data;
  logic [31:0] sys_addr;
  logic [5:0]  region_sel;
  logic [31:0] region_offset;
  logic        decode_err;

  int checks = 0;
  int errors = 0;

  // Reference state
  bit          m_alias;
  bit          m_pri;
  logic [31:0] m_spad;
  logic [31:0] m_fstart;
  int          m_flg;

  always #10 clk = ~clk;

  addr_remap_decoder i_addr_remap_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .sys_addr(sys_addr), .region_sel(region_sel),
    .region_offset(region_offset), .decode_err(decode_err)
  );

  function automatic bit inside_win(longint a, longint lo, longint sz);
    return (a >= lo) && (a < lo + sz);
  endfunction

  task automatic model(input logic [31:0] a, output logic [5:0] s,
                       output logic [31:0] o, output logic e);
    longint al = longint'(a);
    longint flo = longint'(m_fstart) - (longint'(1) << m_flg);
    s = '0; o = '0; e = 1'b0;
    if (inside_win(al, 64'hFF00_0000, 65536)) begin s[0] = 1; o = a - 32'hFF00_0000; end
    else if (inside_win(al, 64'hFE00_0000, 262144)) begin s[1] = 1; o = a - 32'hFE00_0000; end
    else if (al < 16384 && (m_pri || !m_alias)) begin s[2] = 1; o = a; end
    else if (m_alias && al < 16777216) begin s[4] = 1; o = a; end
    else if (flo >= 0 && inside_win(al, flo, longint'(1) << m_flg)) begin
      s[3] = 1; o = 32'(al - flo);
    end
    else if (inside_win(al, longint'(m_spad), 16384)) begin s[2] = 1; o = a - m_spad; end
    else if (inside_win(al, 64'hF000_0000, 16777216)) begin s[4] = 1; o = a - 32'hF000_0000; end
    else if (al < 268435456) begin s[5] = 1; o = a; end
    else e = 1'b1;
  endtask

  task automatic probe(input logic [31:0] a, input string tag);
    logic [5:0] es; logic [31:0] eo; logic ee;
    @(negedge clk);
    sys_addr = a;
    #5;
    model(a, es, eo, ee);
    checks++;
    if (region_sel !== es || region_offset !== eo || decode_err !== ee) begin
      errors++;
      $display("FAIL %s addr=%h actual sel=%b off=%h err=%b expected sel=%b off=%h err=%b",
               tag, a, region_sel, region_offset, decode_err, es, eo, ee);
    end
  endtask

  task automatic wr(input logic [2:0] r, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = r; cfg_wr_data = d;
    @(posedge clk);
    case (r)
      3'd0: if (d[0]) m_alias = 0;
      3'd1: m_pri = d[0];
      3'd2: m_spad = d & 32'hFFFF_C000;
      3'd3: m_fstart = d & 32'hFFFF_F000;
      3'd4: if (d[4:0] >= 12 && d[4:0] <= 20) m_flg = int'(d[4:0]);
      default: ;
    endcase
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_sel = '0; cfg_wr_data = '0; sys_addr = '0;
    m_alias = 1; m_pri = 0; m_spad = 32'h2000_0000; m_fstart = 32'h1000_0000; m_flg = 20;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    probe(32'h0000_0100, "R1");
    probe(32'h0FF0_0000, "R1");
    probe(32'h0FEF_FFFF, "R1");
    probe(32'h2000_0004, "R1");
    // R2 fixed windows at the top
    probe(32'hFF00_1234, "R2");
    probe(32'hFF01_0000, "R2");
    probe(32'hFE03_FFFF, "R2");
    probe(32'hFE04_0000, "R2");
    // R3 Flash and dynamic memory
    probe(32'hF000_0010, "R3");
    probe(32'hF0FF_FFFF, "R3");
    probe(32'hF100_0000, "R3");
    probe(32'h0800_0000, "R3");
    // R10 unmapped
    probe(32'h8000_0000, "R10");
    probe(32'h1000_0000, "R10");
    // R7 overlay
    wr(3'd1, 32'h1);
    probe(32'h0000_0100, "R7");
    probe(32'h0000_3FFF, "R7");
    probe(32'h0000_4000, "R7");
    wr(3'd1, 32'h0);
    probe(32'h0000_0100, "R7");
    // R8 scratchpad relocation
    wr(3'd2, 32'h3000_7FFF);
    probe(32'h3000_4010, "R8");
    probe(32'h3000_8000, "R8");
    probe(32'h2000_0000, "R8");
    // R4 downward function window
    wr(3'd3, 32'h1234_5000);
    wr(3'd4, 32'd13);
    probe(32'h1234_3000, "R4");
    probe(32'h1234_4FFF, "R4");
    probe(32'h1234_5000, "R4");
    probe(32'h1234_2FFF, "R4");
    wr(3'd3, 32'h0800_0000);
    probe(32'h07FF_E000, "R4");
    probe(32'h07FF_C000, "R4");
    // R5 illegal sizes ignored
    wr(3'd4, 32'd25);
    probe(32'h07FF_DFFF, "R5");
    probe(32'h07FF_E000, "R5");
    wr(3'd4, 32'd11);
    probe(32'h07FF_E7FF, "R5");
    probe(32'h07FF_DFFF, "R5");
    wr(3'd4, 32'd20);
    probe(32'h07F0_0000, "R5");
    probe(32'h07EF_FFFF, "R5");
    // R6 clear of the Flash alias
    wr(3'd0, 32'h0);
    probe(32'h0000_0100, "R6");
    wr(3'd0, 32'h1);
    probe(32'h0000_0100, "R6");
    probe(32'h0000_4000, "R6");
    probe(32'h00FF_FFFF, "R6");
    wr(3'd1, 32'h1);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h0);
    probe(32'h0000_0200, "R6");
    probe(32'hF000_0200, "R6");
    // R9 sweep of select encoding
    for (int i = 0; i < 16; i++) probe({i[3:0], 28'h0FF_C000}, "R9");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule